// File: doc/BRIEF.md
# Bus-Watch Trigger and Trace Capture Unit

This block sits beside a CPU bus and watches each valid bus access with two address comparators, A and B. Each comparator can be limited to reads only or to writes only. A trigger-type field combines the two comparators into a trigger condition. In force mode that condition fires on the bus access itself. In tag mode the condition only marks the address as pending, and the trigger fires when an instruction-execute confirm reports that same address.

The trigger drives an 8-entry trace store of bus addresses. In a begin trace, storage starts with the trigger and the run completes when the store is full. In an end trace, the store records every access in a ring and the trigger ends the run, so the store keeps the most recent accesses up to and including the trigger. When a run completes, the arm bit clears and a done flag sets. Software then reads the trace back oldest-first through a pop register, and a count register gives the number of entries held.

Register map (register address : contents):
- 0 is control. Bit 0 is arm, and writing 1 while disarmed starts a run. Bit 1 is done and is read-only. Bit 2 enables read/write qualification for A, and bit 3 is A's required direction (1 = read). Bit 4 enables qualification for B, and bit 5 is B's direction.
- 1 is the trigger register.
- 2 and 3 are the comparator A and B addresses.
- 4 is the trace pop.
- 5 is the count.

Top module: `bus_watch_trace`

## Requirements
- R1: After reset, registers 0, 1, 2, 3, 4 and 5 all read 0.
- R2: In the trigger register, bit 7 selects tag (1) or force (0), bit 6 selects begin (1) or end (0), and bits 3:0 hold the type. Bits 5:4 always read 0. Writes to this register are ignored while arm is 1.
- R3: With type 0, force mode and begin trace, the first access to the A address is stored, followed by the next seven accesses. Then arm clears and done sets, so control reads 0x2. Later accesses are not stored.
- R4: When bit 4 of control is 1, comparator B matches only when the bus direction equals bit 5. When bit 4 is 0, the direction is ignored for B.
- R5: When bit 2 of control is 1, comparator A matches only when the bus direction equals bit 3.
- R6: In tag mode, a comparator match only becomes pending and stores nothing. The trigger fires when the execute confirm reports the pending address. A confirm of any other address discards the pending match.
- R7: In an end trace, every access is stored in a ring that overwrites the oldest entry. The trigger access is stored and completes the run, leaving the last 8 accesses.
- R8: Type 3 (event on A) always runs as a begin trace, even when bit 6 is 0.
- R9: Type 2 triggers on a B match only after an earlier A match in the same run. A B match seen first does not trigger.
- R10: Type 4 triggers on an access that matches A while B does not match.
- R11: Type 1 triggers on A or B. Types 5 to 15 behave as type 0 (A only).
- R12: Reading register 4 returns the oldest entry and removes it. On an empty store it returns 0 and the count stays 0. Register 5 reads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on register 4) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on reg_addr |
| bus_valid | input | 1 | Snooped bus access valid |
| bus_addr | input | 16 | Snooped bus address |
| bus_rd | input | 1 | Snooped direction, 1 = read |
| exec_valid | input | 1 | Instruction-execute confirm valid |
| exec_addr | input | 16 | Address of the executed instruction |

## Verification
The hardest case to reach is a tag-mode match that has to be dropped. For that, the match must be pending, an execute confirm for a different address must arrive in between, and only then can the real address be confirmed. The stimulus drives exactly that order. It then confirms the matched address and makes a further bus access, and shows the store stays empty. Only after that does it re-arm the pending match and confirm it correctly, so that a trace actually starts.

// File: rtl/bus_watch_trace.sv
module bus_watch_trace #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          arm, done, pend, seq_a, trg_q;
  logic [3:0]    rwq;
  logic [7:0]    trig;
  logic [AW-1:0] cmpa, cmpb, pend_addr;
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cond;

  wire wr_ctrl = reg_wr && reg_addr == 3'd0;
  wire wr_trig = reg_wr && reg_addr == 3'd1;
  wire tag     = trig[7];
  wire [3:0] ttype = trig[3:0];
  wire begin_mode = trig[6] || ttype == 4'd3;

  wire hit_a = bus_valid && bus_addr == cmpa && (!rwq[0] || bus_rd == rwq[1]);
  wire hit_b = bus_valid && bus_addr == cmpb && (!rwq[2] || bus_rd == rwq[3]);

  always_comb begin
    case (ttype)
      4'd1:    cond = hit_a || hit_b;
      4'd2:    cond = seq_a && hit_b;
      4'd4:    cond = hit_a && !hit_b;
      default: cond = hit_a;
    endcase
  end

  wire tag_hit = pend && exec_valid && exec_addr == pend_addr;
  wire fire    = arm && !trg_q && (tag ? tag_hit : cond);
  wire push    = arm && bus_valid && (!begin_mode || trg_q || fire);
  wire pop     = reg_rd && reg_addr == 3'd4 && cnt != '0;
  wire full    = cnt == CW'(DEPTH);

  always_comb begin
    cnt_nxt = cnt;
    if (push && !pop && !full)  cnt_nxt = cnt + 1'b1;
    else if (pop && !push)      cnt_nxt = cnt - 1'b1;
  end

  wire finish = arm && (begin_mode ? (push && cnt_nxt == CW'(DEPTH)) : fire);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 1'b0; done <= 1'b0; rwq <= '0; trig <= '0;
      cmpa <= '0; cmpb <= '0; wp <= '0; rp <= '0; cnt <= '0;
      pend <= 1'b0; pend_addr <= '0; seq_a <= 1'b0; trg_q <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop || (push && full)) rp <= nxt(rp);
      cnt <= cnt_nxt;
      if (fire) trg_q <= 1'b1;
      if (finish) begin
        arm  <= 1'b0;
        done <= 1'b1;
      end
      if (arm && tag) begin
        if (exec_valid && pend) pend <= 1'b0;
        if (cond) begin
          pend      <= 1'b1;
          pend_addr <= bus_addr;
        end
      end
      if (arm && ttype == 4'd2 && hit_a) seq_a <= 1'b1;
      if (wr_trig && !arm) trig <= {reg_wdata[7:6], 2'b00, reg_wdata[3:0]};
      if (reg_wr && reg_addr == 3'd2) cmpa <= reg_wdata;
      if (reg_wr && reg_addr == 3'd3) cmpb <= reg_wdata;
      if (wr_ctrl) begin
        rwq <= reg_wdata[5:2];
        if (reg_wdata[0] && !arm) begin
          arm <= 1'b1; done <= 1'b0; cnt <= '0; wp <= '0; rp <= '0;
          pend <= 1'b0; seq_a <= 1'b0; trg_q <= 1'b0;
        end else if (!reg_wdata[0]) begin
          arm <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = AW'({rwq, done, arm});
      3'd1:    reg_rdata = AW'(trig);
      3'd2:    reg_rdata = cmpa;
      3'd3:    reg_rdata = cmpb;
      3'd4:    reg_rdata = (cnt != '0) ? mem[rp] : '0;
      3'd5:    reg_rdata = AW'(cnt);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bus_watch_trace_chk.sv
module bus_watch_trace_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          done,
  input logic [7:0]    trig,
  input logic [CW-1:0] cnt,
  input logic          push,
  input logic          pop,
  input logic          fire,
  input logic          exec_valid
);
  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_trig_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> $stable(trig));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig[5:4] == 2'b00);

  assert_done_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !arm);

  assert_tag_needs_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && trig[7]) |-> exec_valid);

  assert_pop_decrements_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !(arm == 1'b0 && $rose(arm))) |=> (cnt == $past(cnt) - 1'b1) || $rose(arm));
endmodule

bind bus_watch_trace bus_watch_trace_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .done(done), .trig(trig), .cnt(cnt),
  .push(push), .pop(pop), .fire(fire), .exec_valid(exec_valid)
);

// File: tb/test_bus_watch_trace.sv
module test_bus_watch_trace;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic bus_valid = 0, bus_rd = 0, exec_valid = 0;
  logic [15:0] bus_addr = 0, exec_addr = 0;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  bus_watch_trace i_bus_watch_trace (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic bus(input logic [15:0] a, input logic r);
    @(negedge clk); bus_valid = 1; bus_addr = a; bus_rd = r;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic exec(input logic [15:0] a);
    @(negedge clk); exec_valid = 1; exec_addr = a;
    @(negedge clk); exec_valid = 0;
  endtask

  task automatic expect_range(input logic [15:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      bus(first + 16'(i), 1'b0);
      exp_q.push_back(first + 16'(i));
    end
  endtask

  task automatic check_count(input string req, input int n);
    logic [15:0] v;
    rd(3'd5, v); check(req, v, 16'(n));
  endtask

  task automatic drain(input string req);
    logic [15:0] v;
    check_count(req, exp_q.size());
    while (exp_q.size() > 0) begin
      rd(3'd4, v);
      check(req, v, exp_q.pop_front());
    end
    check_count("R12", 0);
  endtask

  task automatic check_done(input string req);
    logic [15:0] v;
    rd(3'd0, v); check(req, v & 16'h3, 16'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk); rst_n = 1;
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); check("R1", v, 0); end

    wr(1, 16'h00FF); rd(1, v); check("R2", v, 16'h00CF);
    wr(0, 16'h0001); wr(1, 16'h0000); rd(1, v); check("R2", v, 16'h00CF);
    wr(0, 16'h0000);

    wr(2, 16'h0100); wr(1, 16'h0040); wr(0, 16'h0001);
    bus(16'h0020, 0); bus(16'h0021, 0);
    bus(16'h0100, 1); exp_q.push_back(16'h0100);
    expect_range(16'h0030, 7);
    check_done("R3"); bus(16'h0037, 0);
    drain("R3");

    wr(1, 16'h0000); wr(0, 16'h0001);
    for (int i = 0; i < 12; i++) bus(16'h0010 + 16'(i), 0);
    bus(16'h0100, 0); check_done("R7");
    for (int i = 5; i < 12; i++) exp_q.push_back(16'h0010 + 16'(i));
    exp_q.push_back(16'h0100);
    drain("R7");

    wr(1, 16'h0040); wr(0, 16'h000D);
    bus(16'h0100, 0); check_count("R5", 0);
    bus(16'h0100, 1); exp_q.push_back(16'h0100);
    expect_range(16'h0050, 7); check_done("R5"); drain("R5");

    wr(2, 16'h0300); wr(3, 16'h0400); wr(1, 16'h0041); wr(0, 16'h0031);
    bus(16'h0400, 0); check_count("R4", 0);
    bus(16'h0400, 1); exp_q.push_back(16'h0400);
    expect_range(16'h0058, 7); check_done("R4"); drain("R4");

    wr(2, 16'h0200); wr(1, 16'h00C0); wr(0, 16'h0001);
    bus(16'h0200, 0); bus(16'h0201, 0); check_count("R6", 0);
    exec(16'h0204); exec(16'h0200); bus(16'h0202, 0); check_count("R6", 0);
    bus(16'h0200, 0); exec(16'h0200);
    expect_range(16'h0060, 8); check_done("R6"); drain("R6");

    wr(2, 16'h0100); wr(1, 16'h0003); wr(0, 16'h0001);
    bus(16'h0011, 0); bus(16'h0012, 0); check_count("R8", 0);
    bus(16'h0100, 0); exp_q.push_back(16'h0100);
    expect_range(16'h0070, 7); check_done("R8"); drain("R8");

    wr(3, 16'h0400); wr(1, 16'h0042); wr(0, 16'h0001);
    bus(16'h0400, 0); check_count("R9", 0);
    bus(16'h0100, 0); check_count("R9", 0);
    bus(16'h0400, 0); exp_q.push_back(16'h0400);
    expect_range(16'h0080, 7); check_done("R9"); drain("R9");

    wr(2, 16'h0500); wr(3, 16'h0500); wr(1, 16'h0044); wr(0, 16'h0031);
    bus(16'h0500, 1); check_count("R10", 0);
    bus(16'h0500, 0); exp_q.push_back(16'h0500);
    expect_range(16'h0090, 7); check_done("R10"); drain("R10");

    wr(2, 16'h0100); wr(3, 16'h0400); wr(1, 16'h0049); wr(0, 16'h0001);
    bus(16'h0400, 0); check_count("R11", 0);
    bus(16'h0100, 0); exp_q.push_back(16'h0100);
    expect_range(16'h00A0, 7); check_done("R11"); drain("R11");

    wr(1, 16'h0041); wr(0, 16'h0001);
    bus(16'h0400, 0); exp_q.push_back(16'h0400);
    expect_range(16'h00B0, 7); check_done("R11"); drain("R11");

    rd(3'd4, v); check("R12", v, 0); check_count("R12", 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule